// File: doc/BRIEF.md
# Periodic Interrupt Pulse Generator

This block produces the active-low interrupt/pulse output of a real-time clock and the interrupt flag that mirrors it. It picks one of four period events coming from the time counter chain: the 64 Hz divider tap, the seconds carry, the minutes carry or the hours carry. It then turns the chosen event into either a latched interrupt or a fixed-width low pulse. The pin is modelled as a release signal: 1 leaves the line open (high), and 0 pulls it low.

In latched interrupt mode, an event holds the output low until the host clears the flag. In pulse mode, the low level lasts a fixed 256 cycles of a 32.768 kHz enable (7.8125 ms), unless the host clears it earlier. At a 1/64 second period this gives a duty of one half. A mask forces the output open. A stop control freezes the pulse-mode state while the clock is halted. Minute and hour carries caused by a 30-second adjust arrive on the same carry inputs, so they trigger events in the same way.

Top module: `irq_pulse_gen`

## Requirements
- R1: After reset the flag is 0 and the output is released (`out_release` = 1).
- R2: The period select picks the event source: 0 = 64 Hz tick, 1 = seconds carry, 2 = minutes carry, 3 = hours carry. A pulse on an unselected source does not set the flag.
- R3: While `mask` = 1, the flag is 0 from the next cycle on, the output is released, and no event sets the flag.
- R4: `out_release` is always the inverse of `irq_flag`.
- R5: In interrupt mode (`irq_mode` = 1), a selected event with the flag at 0 sets the flag in the next cycle. The flag then stays at 1 through any amount of time until `flag_clr` is asserted.
- R6: An event that arrives while the flag is 1 is ignored. It neither extends a pulse nor changes a latched flag.
- R7: In pulse mode (`irq_mode` = 0), the flag clears by itself at the edge of the 256th `tick_32k` enable that is sampled after the edge that set it. This width is the same for every period select.
- R8: `flag_clr` clears the flag in the next cycle in either mode, and it takes priority over an event in the same cycle.
- R9: In pulse mode, while `stop` = 1 the flag and its remaining width are frozen: events, ticks and `flag_clr` have no effect. In interrupt mode, `stop` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_32k | input | 1 | 32.768 kHz enable that times the pulse width |
| tick_64hz | input | 1 | One-cycle pulse from the 64 Hz divider tap |
| sec_carry | input | 1 | One-cycle seconds carry |
| min_carry | input | 1 | One-cycle minutes carry (including an adjust carry) |
| hour_carry | input | 1 | One-cycle hours carry |
| period_sel | input | 2 | Event source select |
| irq_mode | input | 1 | 1 = latched interrupt, 0 = fixed-width pulse |
| mask | input | 1 | 1 forces the output open and the flag to 0 |
| stop | input | 1 | Clock stop; freezes the pulse-mode state |
| flag_clr | input | 1 | Host write of 0 to the flag |
| out_release | output | 1 | 1 = line released, 0 = line driven low |
| irq_flag | output | 1 | Interrupt flag, inverse of the line level |

## Verification
Directed sequences pulse each unselected source while one source is selected, so that a wrong decode of the period select becomes visible. They also hold a latched flag across many cycles to separate latching from self-clearing. A pulse-mode run counts exactly 255 and 256 enables to pin down the width and to separate an off-by-one in the timer. Further cases put `flag_clr` against a same-cycle event, retrigger during a pulse, and apply stop with ticks, events and clears, which separates freezing from merely ignoring events. A seeded random phase then mixes all inputs against a bench model, to catch interactions between mode switches, mask and stop.

// File: rtl/irq_pulse_pkg.sv
package irq_pulse_pkg;
  typedef enum logic [1:0] {
    PER_64HZ = 2'd0,
    PER_SEC  = 2'd1,
    PER_MIN  = 2'd2,
    PER_HOUR = 2'd3
  } period_e;

  localparam int unsigned DEF_PULSE_TICKS = 256;
endpackage

// File: rtl/irq_event_sel.sv
module irq_event_sel
  import irq_pulse_pkg::*;
(
  input  logic       tick_64hz,
  input  logic       sec_carry,
  input  logic       min_carry,
  input  logic       hour_carry,
  input  logic [1:0] period_sel,
  output logic       event_hit
);
  logic [3:0] srcs;
  assign srcs = {hour_carry, min_carry, sec_carry, tick_64hz};

  always_comb begin
    case (period_e'(period_sel))
      PER_64HZ: event_hit = srcs[0];
      PER_SEC:  event_hit = srcs[1];
      PER_MIN:  event_hit = srcs[2];
      default:  event_hit = srcs[3];
    endcase
  end
endmodule

// File: rtl/irq_width_timer.sv
module irq_width_timer #(
  parameter int unsigned PULSE_TICKS = 256,
  localparam int unsigned CNT_W = $clog2(PULSE_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic drop,
  input  logic run,
  input  logic tick,
  output logic expire,
  output logic [CNT_W-1:0] remain
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_TICKS);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = run && tick && (cnt_q == ONE);
  assign remain = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (drop) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= LOAD_VAL;
    end else if (run && tick) begin
      cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic event_hit,
  input  logic expire,
  input  logic irq_mode,
  input  logic mask,
  input  logic stop,
  input  logic flag_clr,
  output logic set_flag,
  output logic drop_flag,
  output logic timer_run,
  output logic flag_q,
  output logic release_q
);
  logic frozen;
  logic flag_nxt;

  assign frozen    = !irq_mode && stop;
  assign timer_run = flag_q && !irq_mode && !stop && !mask;

  always_comb begin
    flag_nxt  = flag_q;
    set_flag  = 1'b0;
    drop_flag = 1'b0;
    if (mask) begin
      flag_nxt  = 1'b0;
      drop_flag = 1'b1;
    end else if (frozen) begin
      flag_nxt  = flag_q;
    end else if (flag_clr) begin
      flag_nxt  = 1'b0;
      drop_flag = 1'b1;
    end else if (!flag_q && event_hit) begin
      flag_nxt  = 1'b1;
      set_flag  = 1'b1;
    end else if (expire) begin
      flag_nxt  = 1'b0;
      drop_flag = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q    <= 1'b0;
      release_q <= 1'b1;
    end else begin
      flag_q    <= flag_nxt;
      release_q <= !flag_nxt;
    end
  end
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen
  import irq_pulse_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = DEF_PULSE_TICKS
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_32k,
  input  logic       tick_64hz,
  input  logic       sec_carry,
  input  logic       min_carry,
  input  logic       hour_carry,
  input  logic [1:0] period_sel,
  input  logic       irq_mode,
  input  logic       mask,
  input  logic       stop,
  input  logic       flag_clr,
  output logic       out_release,
  output logic       irq_flag
);
  localparam int unsigned CNT_W = $clog2(PULSE_TICKS + 1);

  logic event_hit;
  logic expire;
  logic set_flag;
  logic drop_flag;
  logic timer_run;
  logic flag_q;
  logic release_q;
  logic [CNT_W-1:0] remain;

  irq_event_sel u_sel (
    .tick_64hz (tick_64hz),
    .sec_carry (sec_carry),
    .min_carry (min_carry),
    .hour_carry(hour_carry),
    .period_sel(period_sel),
    .event_hit (event_hit)
  );

  irq_width_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .load  (set_flag),
    .drop  (drop_flag),
    .run   (timer_run),
    .tick  (tick_32k),
    .expire(expire),
    .remain(remain)
  );

  irq_flag_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .event_hit(event_hit),
    .expire   (expire),
    .irq_mode (irq_mode),
    .mask     (mask),
    .stop     (stop),
    .flag_clr (flag_clr),
    .set_flag (set_flag),
    .drop_flag(drop_flag),
    .timer_run(timer_run),
    .flag_q   (flag_q),
    .release_q(release_q)
  );

  assign out_release = release_q;
  assign irq_flag    = flag_q;
endmodule

// File: rtl/irq_pulse_gen_chk.sv
module irq_pulse_gen_chk #(
  parameter int unsigned CNT_W = 9
) (
  input logic clk,
  input logic rst,
  input logic event_hit,
  input logic irq_mode,
  input logic mask,
  input logic stop,
  input logic flag_clr,
  input logic irq_flag,
  input logic out_release,
  input logic [CNT_W-1:0] remain
);
  p_inverse_r4: assert property (@(posedge clk) disable iff (rst)
    out_release == !irq_flag);

  p_mask_r3: assert property (@(posedge clk) disable iff (rst)
    mask |=> !irq_flag);

  p_latch_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_mode && irq_flag && !flag_clr && !mask) |=> irq_flag);

  p_set_r5: assert property (@(posedge clk) disable iff (rst)
    (!irq_flag && event_hit && !flag_clr && !mask && !(!irq_mode && stop)) |=> irq_flag);

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !mask && !(!irq_mode && stop)) |=> !irq_flag);

  p_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    (!irq_mode && stop && !mask) |=> ($stable(irq_flag) && $stable(remain)));

  p_width_live_r7: assert property (@(posedge clk) disable iff (rst)
    irq_flag |-> (remain != '0));
endmodule

bind irq_pulse_gen irq_pulse_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .event_hit  (event_hit),
  .irq_mode   (irq_mode),
  .mask       (mask),
  .stop       (stop),
  .flag_clr   (flag_clr),
  .irq_flag   (irq_flag),
  .out_release(out_release),
  .remain     (remain)
);

// File: tb/irq_pulse_gen_test.sv
module irq_pulse_gen_test;
  localparam int PW = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_32k = 0, tick_64hz = 0, sec_carry = 0, min_carry = 0, hour_carry = 0;
  logic [1:0] period_sel = 2'd0;
  logic irq_mode = 0, mask = 0, stop = 0, flag_clr = 0;
  logic out_release, irq_flag;

  logic d_tick = 0, d_t64 = 0, d_sec = 0, d_min = 0, d_hr = 0;
  logic [1:0] d_sel = 2'd0;
  logic d_mode = 0, d_mask = 0, d_stop = 0, d_clr = 0;

  int exp_f = 0;
  int exp_c = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_pulse_gen uut (
    .clk(clk), .rst(rst), .tick_32k(tick_32k), .tick_64hz(tick_64hz),
    .sec_carry(sec_carry), .min_carry(min_carry), .hour_carry(hour_carry),
    .period_sel(period_sel), .irq_mode(irq_mode), .mask(mask), .stop(stop),
    .flag_clr(flag_clr), .out_release(out_release), .irq_flag(irq_flag)
  );

  function automatic int sel_event(logic [1:0] s, logic a, logic b, logic c, logic d);
    case (s)
      2'd0: return int'(a);
      2'd1: return int'(b);
      2'd2: return int'(c);
      default: return int'(d);
    endcase
  endfunction

  task automatic model_update();
    int ev;
    ev = sel_event(d_sel, d_t64, d_sec, d_min, d_hr);
    if (d_mask) begin
      exp_f = 0; exp_c = 0;
    end else if (!d_mode && d_stop) begin
    end else if (d_clr) begin
      exp_f = 0; exp_c = 0;
    end else if (exp_f == 0 && ev == 1) begin
      exp_f = 1; exp_c = PW;
    end else if (exp_f == 1 && !d_mode && d_tick) begin
      if (exp_c == 1) begin exp_f = 0; exp_c = 0; end
      else exp_c = exp_c - 1;
    end
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    @(negedge clk);
    tick_32k = d_tick; tick_64hz = d_t64; sec_carry = d_sec; min_carry = d_min;
    hour_carry = d_hr; period_sel = d_sel; irq_mode = d_mode; mask = d_mask;
    stop = d_stop; flag_clr = d_clr;
    @(posedge clk);
    model_update();
    #1;
    check(tag, int'(irq_flag), exp_f);
    check("R4", int'(out_release), 1 - exp_f);
  endtask

  task automatic quiet();
    d_t64 = 0; d_sec = 0; d_min = 0; d_hr = 0; d_clr = 0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h1234_5678);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check("R1", int'(irq_flag), 0);
    check("R1", int'(out_release), 1);

    // R2: unselected sources ignored, selected one sets (interrupt mode)
    d_mode = 1; d_sel = 2'd1;
    d_t64 = 1; d_min = 1; d_hr = 1; step("R2");
    quiet(); step("R2");
    d_sec = 1; step("R5"); quiet();
    idle(60, "R5");
    d_sec = 1; step("R6"); quiet();
    d_tick = 1; idle(300, "R5"); d_tick = 0;
    d_clr = 1; step("R8"); quiet();
    check("R8", int'(irq_flag), 0);

    // R2: each select value
    for (int s = 0; s < 4; s++) begin
      d_sel = 2'(s);
      d_t64 = (s == 0); d_sec = (s == 1); d_min = (s == 2); d_hr = (s == 3);
      step("R2"); quiet();
      check("R2", int'(irq_flag), 1);
      d_clr = 1; step("R8"); quiet();
    end

    // R7: pulse width with a tick every cycle
    d_mode = 0; d_sel = 2'd0; d_tick = 1;
    d_t64 = 1; step("R7"); quiet();
    idle(255, "R7");
    check("R7", int'(irq_flag), 1);
    step("R7");
    check("R7", int'(irq_flag), 0);

    // R6: retrigger mid-pulse does not extend
    d_t64 = 1; step("R6"); quiet();
    idle(100, "R6");
    d_t64 = 1; step("R6"); quiet();
    idle(154, "R6");
    check("R6", int'(irq_flag), 1);
    step("R6");
    check("R6", int'(irq_flag), 0);

    // R8: clear wins over same-cycle event, and clears a pulse early
    d_t64 = 1; step("R8"); quiet();
    idle(10, "R8");
    d_clr = 1; d_t64 = 1; step("R8"); quiet();
    check("R8", int'(irq_flag), 0);

    // R9: stop freezes pulse state
    d_t64 = 1; step("R9"); quiet();
    idle(20, "R9");
    d_stop = 1;
    for (int i = 0; i < 300; i++) begin
      d_clr = (i % 7 == 0); d_t64 = (i % 5 == 0);
      step("R9");
    end
    quiet();
    check("R9", int'(irq_flag), 1);
    d_stop = 0;
    idle(240, "R9");
    check("R9", int'(irq_flag), 0);
    // stop frozen while flag 0: events ignored
    d_stop = 1; d_t64 = 1; step("R9"); quiet();
    check("R9", int'(irq_flag), 0);
    // stop has no effect in interrupt mode
    d_mode = 1; d_t64 = 1; step("R9"); quiet();
    check("R9", int'(irq_flag), 1);
    d_clr = 1; step("R9"); quiet();
    check("R9", int'(irq_flag), 0);
    d_stop = 0;

    // R3: mask
    d_sec = 0; d_t64 = 1; step("R3"); quiet();
    d_mask = 1; step("R3");
    check("R3", int'(out_release), 1);
    for (int i = 0; i < 20; i++) begin
      d_t64 = 1; d_sec = 1; d_min = 1; d_hr = 1; step("R3");
    end
    quiet();
    check("R3", int'(irq_flag), 0);
    d_mask = 0; step("R3");

    // Random mix against the model
    for (int i = 0; i < 20000; i++) begin
      d_tick = ($urandom % 2) == 0;
      d_t64 = ($urandom % 60) == 0;
      d_sec = ($urandom % 60) == 0;
      d_min = ($urandom % 60) == 0;
      d_hr = ($urandom % 60) == 0;
      d_clr = ($urandom % 700) == 0;
      if (($urandom % 500) == 0) d_sel = 2'($urandom % 4);
      if (($urandom % 1500) == 0) d_mode = ~d_mode;
      if (($urandom % 900) == 0) d_stop = ~d_stop;
      if (($urandom % 1200) == 0) d_mask = ~d_mask;
      step("R2,R6,R7");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule